// File: doc/BRIEF.md
# DMA Channel Interrupt Generator

This block produces the interrupt outputs of a single DMA channel. It compares the channel's running transfer count with a programmed target and raises a sticky completion flag on the cycle the two first become equal. It does not raise that flag while the channel's source side runs in end-of-burst FIFO mode, because in that mode the burst boundary, not the count, ends the transfer.

The block also collects error events from the transfer engine into a sticky 4-bit cause field. A request time-out is always recorded. A burst time-out, an internal buffer overflow and a transfer error acknowledge are recorded only while the engine reports an active burst cycle. Software clears each flag by pulsing the matching bit of a write-one-to-clear input. A single combined interrupt line ORs the completion flag and the cause bits, and each of these terms has its own enable.

Top module: `dma_irq_gen`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after it is released, `done_flag_o`, `err_cause_o`, `err_flag_o` and `irq_o` are all 0.
- R2: When `eob_fifo_mode_i` is 0 on the first cycle in which `xfer_cnt_i` equals `tgt_cnt_i` (the values differed the cycle before), `done_flag_o` is 1 from the next cycle on. A match already present when reset is released does not count as a first match.
- R3: A first match that occurs while `eob_fifo_mode_i` is 1 never sets `done_flag_o`.
- R4: A count that stays equal to the target does not set `done_flag_o` again after the flag has been cleared. Only a new transition into equality sets it.
- R5: `req_tmo_i` high in a cycle sets `err_cause_o[0]` on the next cycle, whatever the value of `burst_act_i`.
- R6: `burst_tmo_i`, `buf_ovf_i` and `xfer_err_i` set `err_cause_o[1]`, `err_cause_o[2]` and `err_cause_o[3]` on the next cycle only if `burst_act_i` is 1 in the same cycle. Otherwise they have no effect on `err_cause_o`.
- R7: Every flag holds its value until a 1 on its own clear bit: `clr_done_i` for `done_flag_o`, and `clr_err_i[k]` for `err_cause_o[k]`. Clearing one bit leaves all the other bits unchanged.
- R8: If a flag's set condition and its clear bit are both active in the same cycle, the flag is 1 on the next cycle.
- R9: `err_flag_o` is 1 exactly when at least one bit of `err_cause_o` is 1.
- R10: `irq_o` = (`done_flag_o` & `irq_en_done_i`) | OR over k of (`err_cause_o[k]` & `irq_en_err_i[k]`). It is combinational from the flags and the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_cnt_i | input | CNT_W | Running transfer count from the datapath |
| tgt_cnt_i | input | CNT_W | Programmed target count |
| eob_fifo_mode_i | input | 1 | Source mode is end-of-burst FIFO; suppresses completion |
| req_tmo_i | input | 1 | Request time-out event |
| burst_tmo_i | input | 1 | Burst time-out event |
| buf_ovf_i | input | 1 | Internal buffer overflow event |
| xfer_err_i | input | 1 | Transfer error acknowledge event |
| burst_act_i | input | 1 | Burst cycle in progress |
| clr_done_i | input | 1 | Write-one-to-clear for the completion flag |
| clr_err_i | input | 4 | Write-one-to-clear per cause bit |
| irq_en_done_i | input | 1 | Enable of the completion term in irq_o |
| irq_en_err_i | input | 4 | Enable per cause bit in irq_o |
| done_flag_o | output | 1 | Sticky completion flag |
| err_cause_o | output | 4 | Sticky cause bits: 0 request time-out, 1 burst time-out, 2 buffer overflow, 3 transfer error |
| err_flag_o | output | 1 | OR of the cause bits |
| irq_o | output | 1 | Combined interrupt line |

## Verification
All state sits in five flag registers and one registered match bit, so a wrong internal value shows at the ports one cycle after the stimulus that exposes it. A bad flag bit shows directly on `done_flag_o` or `err_cause_o`. A stale or wrong match bit shows up as a missing completion or a repeated one on the cycle after the count enters or stays at the target. The bench compares every output against a cycle model on every cycle, so any such divergence is reported on the cycle it appears.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned CAUSE_W = 4;

  localparam int unsigned CI_REQ_TMO   = 0;
  localparam int unsigned CI_BURST_TMO = 1;
  localparam int unsigned CI_BUF_OVF   = 2;
  localparam int unsigned CI_XFER_ERR  = 3;

  typedef logic [CAUSE_W-1:0] cause_t;

  // packed msb-first: req_tmo lands on bit 0
  typedef struct packed {
    logic xfer_err;
    logic buf_ovf;
    logic burst_tmo;
    logic req_tmo;
  } err_evt_t;
endpackage

// File: rtl/dma_irq_cnt_det.sv
module dma_irq_cnt_det #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] tgt_i,
  input  logic             suppress_i,
  output logic             hit_o
);
  logic match, match_q;

  assign match = (cnt_i == tgt_i);

  // reset high: a match present at reset release is not a first match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b1;
    else         match_q <= match;
  end

  assign hit_o = match & ~match_q & ~suppress_i;

  AST_HIT_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o); // R4
endmodule

// File: rtl/dma_irq_err_qual.sv
module dma_irq_err_qual
  import dma_irq_pkg::*;
(
  input  err_evt_t evt_i,
  input  logic     burst_act_i,
  output cause_t   set_o
);
  cause_t raw;
  assign raw = cause_t'(evt_i);

  for (genvar k = 0; k < CAUSE_W; k++) begin : g_qual
    if (k == CI_REQ_TMO) begin : g_free
      assign set_o[k] = raw[k];
    end else begin : g_burst
      assign set_o[k] = raw[k] & burst_act_i;
    end
  end
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;   // set beats clear
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q_o[i]); // R8
    AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o[i] && clr_i[i] && !set_i[i]) |=> !q_o[i]); // R7
    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o[i] && !clr_i[i]) |=> q_o[i]); // R7
    AST_NO_SPONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!q_o[i] && !set_i[i]) |=> !q_o[i]); // R7
  end
endmodule

// File: rtl/dma_irq_gen.sv
module dma_irq_gen
  import dma_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] xfer_cnt_i,
  input  logic [CNT_W-1:0] tgt_cnt_i,
  input  logic             eob_fifo_mode_i,
  input  logic             req_tmo_i,
  input  logic             burst_tmo_i,
  input  logic             buf_ovf_i,
  input  logic             xfer_err_i,
  input  logic             burst_act_i,
  input  logic             clr_done_i,
  input  logic [3:0]       clr_err_i,
  input  logic             irq_en_done_i,
  input  logic [3:0]       irq_en_err_i,
  output logic             done_flag_o,
  output logic [3:0]       err_cause_o,
  output logic             err_flag_o,
  output logic             irq_o
);
  logic     hit;
  err_evt_t evt;
  cause_t   err_set;

  dma_irq_cnt_det #(.CNT_W(CNT_W)) u_cnt_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (xfer_cnt_i),
    .tgt_i      (tgt_cnt_i),
    .suppress_i (eob_fifo_mode_i),
    .hit_o      (hit)
  );

  assign evt = '{xfer_err: xfer_err_i, buf_ovf: buf_ovf_i,
                 burst_tmo: burst_tmo_i, req_tmo: req_tmo_i};

  dma_irq_err_qual u_err_qual (
    .evt_i       (evt),
    .burst_act_i (burst_act_i),
    .set_o       (err_set)
  );

  dma_irq_flags #(.W(1)) u_done_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (clr_done_i),
    .q_o    (done_flag_o)
  );

  dma_irq_flags #(.W(CAUSE_W)) u_err_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_set),
    .clr_i  (clr_err_i),
    .q_o    (err_cause_o)
  );

  assign err_flag_o = |err_cause_o;
  assign irq_o      = (done_flag_o & irq_en_done_i) | (|(err_cause_o & irq_en_err_i));

  AST_DONE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_flag_o) |-> $past(xfer_cnt_i == tgt_cnt_i && !eob_fifo_mode_i)); // R2
  AST_EOB_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eob_fifo_mode_i && !done_flag_o) |=> !done_flag_o); // R3
  AST_HOLD_NO_RETRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(xfer_cnt_i == tgt_cnt_i) && xfer_cnt_i == tgt_cnt_i && !done_flag_o)
      |=> !done_flag_o); // R4
  AST_REQ_TMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_tmo_i |=> err_cause_o[CI_REQ_TMO]); // R5
  for (genvar k = 1; k < CAUSE_W; k++) begin : g_burst_chk
    AST_BURST_QUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_cause_o[k]) |-> $past(burst_act_i)); // R6
  end
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en_done_i && irq_en_err_i == 4'd0) |-> !irq_o); // R10
endmodule

// File: tb/dma_irq_gen_tb.sv
module dma_irq_gen_tb_top;
  localparam int unsigned CNT_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CNT_W-1:0] xfer_cnt_i = '0, tgt_cnt_i = '0;
  logic             eob_fifo_mode_i = 1'b0;
  logic             req_tmo_i = 1'b0, burst_tmo_i = 1'b0, buf_ovf_i = 1'b0, xfer_err_i = 1'b0;
  logic             burst_act_i = 1'b0, clr_done_i = 1'b0, irq_en_done_i = 1'b0;
  logic [3:0]       clr_err_i = '0, irq_en_err_i = '0;
  logic             done_flag_o, err_flag_o, irq_o;
  logic [3:0]       err_cause_o;

  always #5 clk_i = ~clk_i;

  dma_irq_gen #(.CNT_W(CNT_W)) dut_i (.*);

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  // bench model state
  logic       m_done = 0, m_mprev = 1;
  logic [3:0] m_cause = '0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic f_irq(logic d, logic [3:0] c, logic en_d, logic [3:0] en_e);
    return (d & en_d) | (|(c & en_e));
  endfunction

  function automatic logic [3:0] f_err_set(logic rt, logic bt, logic ov, logic xe, logic ba);
    return {xe & ba, ov & ba, bt & ba, rt};
  endfunction

  // inputs already driven; advance one clock and compare all outputs
  task automatic step();
    logic match, hit;
    logic [3:0] es;
    match = (xfer_cnt_i == tgt_cnt_i);
    hit   = match & ~m_mprev & ~eob_fifo_mode_i;
    m_mprev = match;
    m_done  = hit | (m_done & ~clr_done_i);
    es      = f_err_set(req_tmo_i, burst_tmo_i, buf_ovf_i, xfer_err_i, burst_act_i);
    m_cause = es | (m_cause & ~clr_err_i);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R2 done_flag", 32'(done_flag_o), 32'(m_done));
    chk("R6 err_cause", 32'(err_cause_o), 32'(m_cause));
    chk("R9 err_flag", 32'(err_flag_o), 32'(|m_cause));
    chk("R10 irq", 32'(irq_o), 32'(f_irq(m_done, m_cause, irq_en_done_i, irq_en_err_i)));
  endtask

  task automatic idle();
    req_tmo_i = 0; burst_tmo_i = 0; buf_ovf_i = 0; xfer_err_i = 0;
    burst_act_i = 0; clr_done_i = 0; clr_err_i = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd2718);
    tgt_cnt_i = 16'd5; xfer_cnt_i = 16'd0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 done rst", 32'(done_flag_o), 0);
    chk("R1 cause rst", 32'(err_cause_o), 0);
    chk("R1 irq rst", 32'(irq_o), 0);
    rst_ni = 1'b1;
    irq_en_done_i = 1; irq_en_err_i = 4'hF;
    step();
    chk("R1 first cycle", 32'({done_flag_o, err_cause_o, irq_o}), 0);

    // R2 count reaches target
    xfer_cnt_i = 4; step();
    chk("R2 not yet", 32'(done_flag_o), 0);
    xfer_cnt_i = 5; step();
    chk("R2 raised", 32'(done_flag_o), 1);
    chk("R10 irq done", 32'(irq_o), 1);
    // R4 hold at target, clear, no retrigger
    clr_done_i = 1; step(); clr_done_i = 0;
    chk("R4 cleared", 32'(done_flag_o), 0);
    repeat (3) step();
    chk("R4 no retrig", 32'(done_flag_o), 0);
    // R10 enable off
    xfer_cnt_i = 6; step(); xfer_cnt_i = 5; irq_en_done_i = 0; step();
    chk("R2 re-entry", 32'(done_flag_o), 1);
    chk("R10 masked", 32'(irq_o), 0);
    irq_en_done_i = 1;
    clr_done_i = 1; step(); clr_done_i = 0;

    // R3 eob mode suppresses
    eob_fifo_mode_i = 1; tgt_cnt_i = 7; xfer_cnt_i = 6; step();
    xfer_cnt_i = 7; step();
    chk("R3 suppressed", 32'(done_flag_o), 0);
    eob_fifo_mode_i = 0; step();
    chk("R3 stays quiet", 32'(done_flag_o), 0);

    // R5 request timeout without burst
    req_tmo_i = 1; step(); idle();
    chk("R5 req_tmo", 32'(err_cause_o), 4'b0001);
    // R6 burst-qualified causes
    burst_tmo_i = 1; buf_ovf_i = 1; xfer_err_i = 1; step(); idle();
    chk("R6 no burst", 32'(err_cause_o), 4'b0001);
    burst_act_i = 1; burst_tmo_i = 1; step(); idle();
    chk("R6 burst_tmo", 32'(err_cause_o), 4'b0011);
    burst_act_i = 1; buf_ovf_i = 1; xfer_err_i = 1; step(); idle();
    chk("R6 all", 32'(err_cause_o), 4'b1111);
    chk("R9 err_flag", 32'(err_flag_o), 1);
    // R7 per-bit clear
    clr_err_i = 4'b0010; step(); idle();
    chk("R7 clr bit1", 32'(err_cause_o), 4'b1101);
    irq_en_err_i = 4'b0010;
    step();
    chk("R10 only bit1 enabled", 32'(irq_o), 0);
    irq_en_err_i = 4'hF;
    // R8 set wins
    req_tmo_i = 1; clr_err_i = 4'b0001; step(); idle();
    chk("R8 set wins", 32'(err_cause_o[0]), 1);
    clr_err_i = 4'hF; step(); idle();
    chk("R7 all clear", 32'(err_cause_o), 0);
    chk("R9 err_flag low", 32'(err_flag_o), 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      r = $urandom;
      xfer_cnt_i      = 16'(r[1:0]);
      tgt_cnt_i       = 16'(r[3:2]);
      eob_fifo_mode_i = (r[6:4] == 0);
      req_tmo_i       = (r[10:7] == 0);
      burst_tmo_i     = (r[13:11] == 0);
      buf_ovf_i       = (r[16:14] == 0);
      xfer_err_i      = (r[19:17] == 0);
      burst_act_i     = r[20];
      clr_done_i      = (r[22:21] == 0);
      clr_err_i       = (r[24:23] == 0) ? 4'(r[28:25]) : 4'd0;
      irq_en_done_i   = r[29];
      irq_en_err_i    = {r[30], r[31], r[0], r[5]};
      step();
    end
    idle();
    finish_run();
  end
endmodule